// File: doc/BRIEF.md
# Grouped Carry Adder-Subtractor

This block adds or subtracts two 16-bit two's-complement operands with no clock and no storage. A result appears at the outputs as soon as the inputs settle. A subtract request turns into an ordinary addition. Every bit of the second operand is flipped through an XOR gate. The extra one needed to negate that operand enters as the carry into the lowest bit. The outputs are the sum, the unsigned carry-out and a signed overflow flag.

The operand width is split into equal groups, four bits each by default. Inside a group the carry ripples from bit to bit. A compile-time mode chooses how a carry moves from one group to the next:

- **Skip mode:** a group whose bits all propagate sends its incoming carry straight to its outgoing carry, bypassing its own ripple chain.
- **Select mode:** every group after the first computes its sum twice, once for an incoming carry of 0 and once for 1. The carry that actually arrives picks one of the two results.

Both modes must give results that match bit for bit.

Top module: `grp_addsub`

## Requirements
- R1: With `sub_i`=0, {`cout_o`,`sum_o`} equals the 17-bit sum `a_i` + `b_i` + `cin_i`.
- R2: With `sub_i`=1, {`cout_o`,`sum_o`} equals `a_i` + (bitwise NOT `b_i`) + 1. So `cout_o`=1 exactly when `a_i` >= `b_i` as unsigned numbers.
- R3: With `sub_i`=1, `cin_i` has no effect on any output.
- R4: `ovf_o` is 1 exactly when the signed result does not fit in 16 bits. This is the carry into bit 15 XOR the carry out of bit 15. For an add, that means both operands share a sign that differs from the result's sign. For a subtract, the operands differ in sign and the result's sign differs from `a_i`.
- R5: In carry-skip mode (`MODE`=CARRY_SKIP, the default), a group whose four bits all propagate passes its incoming carry to its outgoing carry unchanged. Any other group produces its carry-out from its own ripple chain.
- R6: In carry-select mode (`MODE`=CARRY_SELECT), each group after the first chooses between two precomputed results using its incoming carry. The result for carry-in 1 is always the result for carry-in 0 plus one.
- R7: Both modes give identical outputs for every input.
- R8: Boundary operands behave as follows:
  - 0xFFFF + 1 gives sum 0, carry 1 and no overflow.
  - 0x7FFF + 1 gives 0x8000 with overflow.
  - 0x8000 − 1 gives 0x7FFF with overflow and carry 1.
  - 0x5555 + 0xAAAA + carry 1 gives sum 0 and carry 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand (subtrahend when subtracting) |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| cin_i | input | 1 | Carry into bit 0; ignored when subtracting |
| sum_o | output | 16 | Result bits |
| cout_o | output | 1 | Carry out of bit 15 |
| ovf_o | output | 1 | Signed overflow |

## Verification
The hardest case to reach is a carry that enters the lowest group and must cross every group because all sixteen bits propagate. Only in that case does the skip path carry the result, and only then does each select group's choice depend on a carry that came all the way from bit 0. Random operands almost never make all bits propagate together. The stimulus therefore adds directed complementary pairs such as 0x5555/0xAAAA and 0xFFFF/0x0000 with a carry-in, plus their subtract forms. It also adds random vectors in which the second operand is forced to the complement of the first within chosen groups, so that many partial full-propagate patterns appear. Each vector goes to a skip-mode instance and a select-mode instance side by side.

// File: rtl/grp_addsub_pkg.sv
package grp_addsub_pkg;

  typedef enum logic [0:0] {
    CARRY_SKIP   = 1'b0,
    CARRY_SELECT = 1'b1
  } carry_mode_e;

endpackage

// File: rtl/grp_addsub_ripple.sv
module grp_addsub_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         cmsb_o,
  output logic         prop_all_o
);

  logic [W-1:0] gen;
  logic [W-1:0] prop;

  assign gen  = a_i & b_i;
  assign prop = a_i ^ b_i;

  always_comb begin
    logic c;
    c      = cin_i;
    cmsb_o = 1'b0;
    sum_o  = '0;
    for (int i = 0; i < W; i++) begin
      sum_o[i] = prop[i] ^ c;
      if (i == W - 1) cmsb_o = c;
      c = gen[i] | (prop[i] & c);
    end
    cout_o = c;
  end

  assign prop_all_o = &prop;

endmodule

// File: rtl/grp_addsub_skip_group.sv
module grp_addsub_skip_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         cmsb_o
);

  logic rip_cout;
  logic prop_all;

  grp_addsub_ripple #(.W(W)) u_rip (
    .a_i       (a_i),
    .b_i       (b_i),
    .cin_i     (cin_i),
    .sum_o     (sum_o),
    .cout_o    (rip_cout),
    .cmsb_o    (cmsb_o),
    .prop_all_o(prop_all)
  );

  // bypass multiplexer: forward the incoming carry when the whole group propagates
  assign cout_o = prop_all ? cin_i : rip_cout;

  always_comb begin
    logic [W:0] grp_ref;
    grp_ref = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    if (prop_all) begin
      a_r5_skip_forward: assert (cout_o == cin_i)
        else $error("R5 skip group did not forward carry");
    end
    a_r5_group_carry: assert (cout_o == grp_ref[W])
      else $error("R5 skip group carry-out wrong");
  end

endmodule

// File: rtl/grp_addsub_select_group.sv
module grp_addsub_select_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         cmsb_o
);

  logic [W-1:0] s_lo, s_hi;
  logic         c_lo, c_hi;
  logic         m_lo, m_hi;
  logic         p_lo, p_hi;

  grp_addsub_ripple #(.W(W)) u_rip_c0 (
    .a_i       (a_i),
    .b_i       (b_i),
    .cin_i     (1'b0),
    .sum_o     (s_lo),
    .cout_o    (c_lo),
    .cmsb_o    (m_lo),
    .prop_all_o(p_lo)
  );

  grp_addsub_ripple #(.W(W)) u_rip_c1 (
    .a_i       (a_i),
    .b_i       (b_i),
    .cin_i     (1'b1),
    .sum_o     (s_hi),
    .cout_o    (c_hi),
    .cmsb_o    (m_hi),
    .prop_all_o(p_hi)
  );

  always_comb begin
    if (cin_i) begin
      sum_o  = s_hi;
      cout_o = c_hi;
      cmsb_o = m_hi;
    end else begin
      sum_o  = s_lo;
      cout_o = c_lo;
      cmsb_o = m_lo;
    end
  end

  always_comb begin
    a_r6_select_pair: assert ({c_hi, s_hi} == ({c_lo, s_lo} + {{W{1'b0}}, 1'b1}))
      else $error("R6 precomputed pair not one apart");
    if (p_lo && p_hi) begin
      a_r6_select_prop: assert (!c_lo && c_hi)
        else $error("R6 propagating group carries wrong");
    end
  end

endmodule

// File: rtl/grp_addsub.sv
module grp_addsub #(
  parameter int                          WIDTH = 16,
  parameter int                          GW    = 4,
  parameter grp_addsub_pkg::carry_mode_e MODE  = grp_addsub_pkg::CARRY_SKIP
) (
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  input  logic        sub_i,
  input  logic        cin_i,
  output logic [15:0] sum_o,
  output logic        cout_o,
  output logic        ovf_o
);

  localparam int NG = WIDTH / GW;

  logic [WIDTH-1:0] b_eff;
  logic             cin_eff;
  logic [NG:0]      gc;
  logic [NG-1:0]    gmsb;

  assign b_eff   = b_i ^ {WIDTH{sub_i}};
  assign cin_eff = sub_i | cin_i;
  assign gc[0]   = cin_eff;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    if (MODE == grp_addsub_pkg::CARRY_SELECT && g == 0) begin : g_first
      logic pa;
      grp_addsub_ripple #(.W(GW)) u_grp (
        .a_i       (a_i[g*GW +: GW]),
        .b_i       (b_eff[g*GW +: GW]),
        .cin_i     (gc[g]),
        .sum_o     (sum_o[g*GW +: GW]),
        .cout_o    (gc[g+1]),
        .cmsb_o    (gmsb[g]),
        .prop_all_o(pa)
      );
      always_comb begin
        if (pa) begin
          a_r6_first_prop: assert (gc[g+1] == gc[g])
            else $error("R6 first group carry wrong");
        end
      end
    end else if (MODE == grp_addsub_pkg::CARRY_SELECT) begin : g_sel
      grp_addsub_select_group #(.W(GW)) u_grp (
        .a_i   (a_i[g*GW +: GW]),
        .b_i   (b_eff[g*GW +: GW]),
        .cin_i (gc[g]),
        .sum_o (sum_o[g*GW +: GW]),
        .cout_o(gc[g+1]),
        .cmsb_o(gmsb[g])
      );
    end else begin : g_skip
      grp_addsub_skip_group #(.W(GW)) u_grp (
        .a_i   (a_i[g*GW +: GW]),
        .b_i   (b_eff[g*GW +: GW]),
        .cin_i (gc[g]),
        .sum_o (sum_o[g*GW +: GW]),
        .cout_o(gc[g+1]),
        .cmsb_o(gmsb[g])
      );
    end
  end

  assign cout_o = gc[NG];
  assign ovf_o  = gmsb[NG-1] ^ gc[NG];

  always_comb begin
    logic [WIDTH:0] full_ref;
    logic [GW-1:0]  part;
    full_ref = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_eff};
    a_r1_sum_matches: assert ({cout_o, sum_o} == full_ref)
      else $error("R1/R2 sum mismatch");
    a_r4_ovf_sign: assert (ovf_o == ((a_i[WIDTH-1] == b_eff[WIDTH-1]) &&
                                     (sum_o[WIDTH-1] != a_i[WIDTH-1])))
      else $error("R4 overflow flag wrong");
    for (int g = 0; g < NG; g++) begin
      part = {1'b0, a_i[g*GW +: GW-1]} + {1'b0, b_eff[g*GW +: GW-1]} +
             {{(GW-1){1'b0}}, gc[g]};
      a_r4_msb_carry: assert (gmsb[g] == part[GW-1])
        else $error("R4 carry into group top bit wrong");
    end
  end

endmodule

// File: tb/grp_addsub_tb.sv
module grp_addsub_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [15:0] a, b;
  logic        sub, cin;
  logic [15:0] sum_k, sum_s;
  logic        cout_k, cout_s, ovf_k, ovf_s;
  int          checks = 0;
  int          errors = 0;
  bit          done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grp_addsub #(.MODE(grp_addsub_pkg::CARRY_SKIP)) u_dut (
    .a_i(a), .b_i(b), .sub_i(sub), .cin_i(cin),
    .sum_o(sum_k), .cout_o(cout_k), .ovf_o(ovf_k)
  );

  grp_addsub #(.MODE(grp_addsub_pkg::CARRY_SELECT)) u_dut_sel (
    .a_i(a), .b_i(b), .sub_i(sub), .cin_i(cin),
    .sum_o(sum_s), .cout_o(cout_s), .ovf_o(ovf_s)
  );

  function automatic logic [17:0] model(input logic [15:0] x, input logic [15:0] y,
                                        input logic s, input logic c);
    logic [15:0] ye;
    logic [16:0] t;
    logic        v;
    ye = s ? ~y : y;
    t  = {1'b0, x} + {1'b0, ye} + {16'd0, (s ? 1'b1 : c)};
    v  = (x[15] == ye[15]) && (t[15] != x[15]);
    return {v, t[16], t[15:0]};
  endfunction

  task automatic drive(input logic [15:0] x, input logic [15:0] y,
                       input logic s, input logic c);
    @(negedge clk);
    a = x; b = y; sub = s; cin = c;
    @(posedge clk);
    #1;
  endtask

  task automatic check_both(input string req);
    logic [17:0] exp;
    exp = model(a, b, sub, cin);
    checks++;
    if ({ovf_k, cout_k, sum_k} != exp) begin
      errors++;
      $display("FAIL %s R5 skip a=%h b=%h sub=%0d cin=%0d got %h exp %h",
               req, a, b, sub, cin, {ovf_k, cout_k, sum_k}, exp);
    end
    checks++;
    if ({ovf_s, cout_s, sum_s} != exp) begin
      errors++;
      $display("FAIL %s R6 select a=%h b=%h sub=%0d cin=%0d got %h exp %h",
               req, a, b, sub, cin, {ovf_s, cout_s, sum_s}, exp);
    end
    checks++;
    if ({ovf_s, cout_s, sum_s} != {ovf_k, cout_k, sum_k}) begin
      errors++;
      $display("FAIL R7 modes differ got %h exp %h",
               {ovf_s, cout_s, sum_s}, {ovf_k, cout_k, sum_k});
    end
  endtask

  task automatic check_exact(input string req, input logic [17:0] exp);
    checks++;
    if ({ovf_k, cout_k, sum_k} != exp) begin
      errors++;
      $display("FAIL %s skip got %h exp %h", req, {ovf_k, cout_k, sum_k}, exp);
    end
    checks++;
    if ({ovf_s, cout_s, sum_s} != exp) begin
      errors++;
      $display("FAIL %s select got %h exp %h", req, {ovf_s, cout_s, sum_s}, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got running exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [17:0] r_c0;
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd2718);
    a = '0; b = '0; sub = 1'b0; cin = 1'b0;

    // idle inputs give all-zero outputs
    drive(16'h0000, 16'h0000, 1'b0, 1'b0);
    check_exact("R1 zero", 18'h00000);

    // R8 boundary operands
    drive(16'hFFFF, 16'h0001, 1'b0, 1'b0);
    check_exact("R8 ffff+1", {1'b0, 1'b1, 16'h0000});
    drive(16'h7FFF, 16'h0001, 1'b0, 1'b0);
    check_exact("R8 7fff+1", {1'b1, 1'b0, 16'h8000});
    drive(16'h8000, 16'h0001, 1'b1, 1'b0);
    check_exact("R8 8000-1", {1'b1, 1'b1, 16'h7FFF});
    drive(16'h5555, 16'hAAAA, 1'b0, 1'b1);
    check_exact("R8 full propagate", {1'b0, 1'b1, 16'h0000});
    drive(16'hFFFF, 16'h0000, 1'b0, 1'b1);
    check_exact("R5 skip chain", {1'b0, 1'b1, 16'h0000});
    drive(16'h1234, 16'h1234, 1'b1, 1'b0);
    check_exact("R2 equal sub", {1'b0, 1'b1, 16'h0000});
    drive(16'h0003, 16'h0005, 1'b1, 1'b0);
    check_exact("R2 borrow", {1'b0, 1'b0, 16'hFFFE});
    drive(16'h8000, 16'h8000, 1'b0, 1'b0);
    check_exact("R4 neg overflow", {1'b1, 1'b1, 16'h0000});

    // R3: carry-in has no effect while subtracting
    for (int k = 0; k < 40; k++) begin
      logic [15:0] x, y;
      x = 16'($urandom);
      y = 16'($urandom);
      drive(x, y, 1'b1, 1'b0);
      r_c0 = {ovf_k, cout_k, sum_k};
      drive(x, y, 1'b1, 1'b1);
      check_exact("R3 cin ignored", r_c0);
    end

    // random mix plus group-complement patterns to force propagates
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] x, y, mask;
      logic        s, c;
      x    = 16'($urandom);
      y    = 16'($urandom);
      s    = 1'($urandom);
      c    = 1'($urandom);
      mask = '0;
      for (int g = 0; g < 4; g++)
        if ($urandom % 3 == 0) mask[g*4 +: 4] = 4'hF;
      if (k % 2 == 1) begin
        if (s) y = (y & ~mask) | (x & mask);
        else   y = (y & ~mask) | (~x & mask);
      end
      drive(x, y, s, c);
      check_both(s ? "R2 R4" : "R1 R4");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule